// File: doc/BRIEF.md
# Programmable Watchdog Reset Timer

A software-refreshed watchdog that raises a one-cycle reset request when software stops writing to it in time. Software reaches it through one 8-bit control register. The register holds an enable flag, a reset-trigger flag and a 6-bit timeout value. These bits load a 7-bit down counter in reversed order. The top bit of that counter is the reset-trigger flag. It starts at 1, and the reset request fires at the moment it falls to 0.

A two-stage prescaler divides the oscillator clock and sets the rate at which the counter steps down. The default division is 12 followed by 256, which gives one step every 3072 cycles. A timeout value `t` therefore gives a period of `(t+1)` steps, which is 3072 to 196608 cycles at the default division. Software refreshes the watchdog by writing the register again before the period runs out. After the reset request fires, the block returns to its power-on state on its own.

Top module: `wdog_timer`

## Requirements
- R1: After external reset `rd_data` reads 0xFE: the enable flag (bit 0) is 0, and the trigger flag and all timeout bits are 1. `wdt_rst` is 0.
- R2: Register layout. Bit 0 is the enable flag and bit 1 is the trigger flag, which is counter bit 6. Bits 7 down to 2 map to counter bits 0 up to 5, so bit 7 is the counter LSB. A read returns the live counter in this layout.
- R3: A write loads the counter from `wr_data` through the R2 mapping and restarts the prescaler. The new contents are readable in the cycle after the write.
- R4: Some writes leave the block enabled, either because it already was or because `wr_data[0]` is 1. If such a write has `wr_data[1]`=0, `wr_reset` pulses in the cycle right after the write.
- R5: While enabled, the counter steps down once every DIV_LO*DIV_HI cycles. After a write with timeout value t and trigger flag 1, `wdt_rst` pulses after exactly (t+1)*DIV_LO*DIV_HI clock edges. This holds for t=0 and t=63.
- R6: While disabled, the counter and prescaler hold their values and no pulse is produced. This includes writes with `wr_data[1]`=0 and `wr_data[0]`=0, which only load the counter.
- R7: Once enabled, a write with `wr_data[0]`=0 does not disable the block. Only external reset or a fired pulse clears the enable flag.
- R8: `wdt_rst` is high for exactly one cycle. In that cycle `rd_data` already reads 0xFE and the block is disabled.
- R9: Rewriting the register before the period runs out prevents any pulse, however many times it is repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | External reset, active low, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Register read value (live counter and enable flag) |
| wdt_rst | output | 1 | Reset request, one-cycle pulse |

## Verification
The embedded assertions check several properties on every cycle:
- the pulse lasts one cycle and leaves the register at 0xFE;
- the block holds still while disabled;
- the enable flag falls only when a pulse fires;
- the counter never moves by more than one step without a write.

Only the directed scenarios can show the exact expiry cycle for each timeout value, the reversed bit mapping seen through reads, the immediate pulse when the trigger flag is cleared, and that repeated refreshes keep the pulse away.

// File: rtl/wdog_timer.sv
module wdog_timer #(
  parameter int DIV_LO = 12,
  parameter int DIV_HI = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       wdt_rst
);
  localparam int LO_W = (DIV_LO > 1) ? $clog2(DIV_LO) : 1;
  localparam int HI_W = (DIV_HI > 1) ? $clog2(DIV_HI) : 1;
  localparam logic [LO_W-1:0] LO_TOP = LO_W'(DIV_LO - 1);
  localparam logic [HI_W-1:0] HI_TOP = HI_W'(DIV_HI - 1);

  logic            en_q;
  logic [6:0]      cnt_q;
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            pulse_q;

  // register bit 7 -> counter bit 0 ... register bit 1 -> counter bit 6
  wire [6:0] wr_cnt = {wr_data[1], wr_data[2], wr_data[3], wr_data[4],
                       wr_data[5], wr_data[6], wr_data[7]};
  wire lo_wrap = (lo_q == LO_TOP);
  wire hi_wrap = (hi_q == HI_TOP);
  wire tick    = en_q && lo_wrap && hi_wrap;
  wire en_nx   = en_q | (wr_en & wr_data[0]);
  wire [6:0] cnt_nx = wr_en ? wr_cnt : (tick ? cnt_q - 7'd1 : cnt_q);
  wire fire    = en_nx && !cnt_nx[6] && (wr_en || cnt_q[6]);

  always_ff @(posedge clk) begin
    if (!rst_n || fire) begin
      en_q    <= 1'b0;
      cnt_q   <= 7'h7F;
      lo_q    <= '0;
      hi_q    <= '0;
      pulse_q <= fire && rst_n;
    end else begin
      pulse_q <= 1'b0;
      en_q    <= en_nx;
      cnt_q   <= cnt_nx;
      if (wr_en) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (en_q) begin
        lo_q <= lo_wrap ? '0 : lo_q + 1'b1;
        if (lo_wrap) hi_q <= hi_wrap ? '0 : hi_q + 1'b1;
      end
    end
  end

  assign rd_data = {cnt_q[0], cnt_q[1], cnt_q[2], cnt_q[3],
                    cnt_q[4], cnt_q[5], cnt_q[6], en_q};
  assign wdt_rst = pulse_q;

  p_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> !wdt_rst);
  p_post_fire_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |-> (rd_data == 8'hFE));
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_en) |=> ($stable(cnt_q) && $stable(lo_q) && !wdt_rst));
  p_sticky_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> wdt_rst);
  p_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wr_en) |=> (wdt_rst || cnt_q == $past(cnt_q)
                          || cnt_q == $past(cnt_q) - 7'd1));
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  localparam int DL = 3;
  localparam int DH = 4;
  localparam int P  = DL * DH;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic wdt_rst;
  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  wdog_timer #(.DIV_LO(DL), .DIV_HI(DH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wdt_rst(wdt_rst));

  always #10 clk = ~clk;
  always @(negedge clk) if (rst_n && wdt_rst) pulses++;

  function automatic logic [7:0] enc(input logic [5:0] t, input logic sr, input logic c);
    logic [7:0] d;
    for (int j = 0; j < 6; j++) d[7-j] = t[j];
    d[1] = sr;
    d[0] = c;
    return d;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  // called at the negedge after a write edge; expects the pulse after n edges
  task automatic expect_fire(input string req, input int n);
    repeat (n - 1) @(posedge clk);
    @(negedge clk); chk({req, " no early pulse"}, wdt_rst, 0);
    @(posedge clk);
    @(negedge clk); chk({req, " pulse"}, wdt_rst, 1);
    chk("R8 state at pulse", rd_data, 8'hFE);
    @(negedge clk); chk("R8 one cycle", wdt_rst, 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset value", rd_data, 8'hFE);
    chk("R1 no pulse", wdt_rst, 0);
  endtask

  task automatic t_disabled_hold();
    int p0 = pulses;
    repeat (100) @(negedge clk);
    chk("R6 held value", rd_data, 8'hFE);
    wr(8'h54);
    chk("R6 loaded not fired", wdt_rst, 0);
    chk("R6 readback", rd_data, 8'h54);
    repeat (5 * P) @(negedge clk);
    chk("R6 still held", rd_data, 8'h54);
    chk("R6 no pulses", pulses - p0, 0);
  endtask

  task automatic t_period(input logic [5:0] t);
    wr(enc(t, 1'b1, 1'b1));
    chk("R3 readback after write", rd_data, enc(t, 1'b1, 1'b1));
    expect_fire("R5 period", (t + 1) * P);
  endtask

  task automatic t_mid_read();
    wr(enc(6'd5, 1'b1, 1'b1));
    repeat (2 * P) @(posedge clk);
    @(negedge clk);
    chk("R2 reversed live count", rd_data, enc(6'd3, 1'b1, 1'b1));
    expect_fire("R5 after read", 4 * P);
  endtask

  task automatic t_sr_clear();
    wr(enc(6'd10, 1'b1, 1'b1));
    repeat (5) @(negedge clk);
    wr(enc(6'd10, 1'b0, 1'b1));
    chk("R4 immediate pulse", wdt_rst, 1);
    chk("R8 state after immediate", rd_data, 8'hFE);
    @(negedge clk); chk("R8 one cycle immediate", wdt_rst, 0);
    wr(enc(6'd7, 1'b0, 1'b1));
    chk("R4 enable with trigger clear", wdt_rst, 1);
  endtask

  task automatic t_sticky();
    wr(enc(6'd5, 1'b1, 1'b1));
    repeat (3) @(negedge clk);
    wr(enc(6'd3, 1'b1, 1'b0));
    chk("R7 enable kept", rd_data[0], 1);
    expect_fire("R7 still counting", 4 * P);
  endtask

  task automatic t_refresh();
    int p0;
    wr(enc(6'd1, 1'b1, 1'b1));
    p0 = pulses;
    for (int i = 0; i < 6; i++) begin
      repeat (2 * P - 5) @(posedge clk);
      wr(enc(6'd1, 1'b1, 1'b1));
    end
    chk("R9 no pulse while refreshed", pulses - p0, 0);
    expect_fire("R9 expiry after refresh stops", 2 * P);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_disabled_hold();
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_period(6'd2);
    t_reset();
    t_period(6'd0);
    t_period(6'd63);
    t_mid_read();
    t_sr_clear();
    t_sticky();
    t_refresh();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule